// File: doc/BRIEF.md
# Debug-Controlled FIFO Access Front-End

This block puts a small synchronous FIFO behind two debug control words so that a debug agent can push and pop entries without touching the functional pins. There is one control word for the write side and one for the read side. Each word has a takeover bit that selects, through a multiplexer, whether the FIFO takes its request and data from the functional pins or from the debug word.

The debug agent cannot produce single-cycle strobes, because its request bits are levels held for many clock cycles. Each debug request line therefore passes through an edge detector. The detector turns a 0-to-1 change of the level into one request lasting one cycle, so that one debug access moves exactly one entry.

Status goes back on two probe words. The write-side probe holds the full flag. The read-side probe holds the registered read data and the empty flag. The same data and flags also drive the functional outputs.

Top module: `dbg_fifo_frontend`

## Requirements
- R1: After reset the FIFO is empty: the empty flag is 1, the full flag is 0 and the read data is 0.
- R2: The write control word is 10 bits wide (DATA_W+2 in general). Bits 7:0 carry the data, bit 8 is the request and bit 9 is the takeover select. When bit 9 is 1, the FIFO writes the data from bits 7:0.
- R3: When write bit 9 is 0, the FIFO write data and write request come from the pins, and the data and request bits of the debug word have no effect.
- R4: Driving the write word with 0x200|v, then 0x300|v, then 0 stores exactly one entry, whose value is v.
- R5: A debug request level held high for any number of cycles gives exactly one single-cycle access, and only on the cycle of its 0-to-1 change.
- R6: In the read control word, bit 0 is the takeover select and bit 1 is the request. Driving 0x1 and then 0x3 removes exactly one entry.
- R7: In the read probe word, bits 7:0 hold the read data and bit 8 holds the empty flag.
- R8: The write probe bit reports the full flag. It is 1 exactly when DEPTH entries are stored.
- R9: A write request while the FIFO is full is ignored: no entry is lost and none is added.
- R10: A read request while the FIFO is empty is ignored: the read data keeps its value and the FIFO stays empty.
- R11: Entries leave in the order they were written. The read data is registered and shows the entry on the clock edge that accepts the read.
- R12: When read bit 0 is 0, the pin read request drives the FIFO and the debug read request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_wr_en | input | 1 | Functional write strobe, one cycle per entry |
| pin_wr_data | input | 8 | Functional write data |
| pin_rd_en | input | 1 | Functional read strobe, one cycle per entry |
| dbg_wr_word | input | 10 | Debug write control: data, request and select |
| dbg_rd_word | input | 2 | Debug read control: select and request |
| fifo_rd_data | output | 8 | Registered read data |
| fifo_full | output | 1 | Full flag |
| fifo_empty | output | 1 | Empty flag |
| probe_wr_word | output | 1 | Write-side probe: full flag |
| probe_rd_word | output | 9 | Read-side probe: empty flag and read data |

## Verification
The assertions assume that the reset is held for at least one clock edge, and that the functional pin strobes are single-cycle pulses while their side is not taken over. The assertions on overflow and underflow only compare state across a refused access. They depend on nothing about how often requests arrive.

The stimulus changes inputs only on falling clock edges. It drives the debug words through the full set/request/clear sequence and holds each request for several cycles. It fills the FIFO to exactly DEPTH entries and drains it to empty, and it makes the refused accesses only at those two limits. Expected contents come from a queue model in the bench.

// File: rtl/dbg_fifo_pkg.sv
package dbg_fifo_pkg;
    // Read control word layout (the decoder depends on these positions)
    localparam int RD_SEL_BIT = 0;
    localparam int RD_REQ_BIT = 1;
    localparam int RD_WORD_W  = 2;

    // Source of a FIFO port
    typedef enum logic {
        SRC_PINS  = 1'b0,
        SRC_DEBUG = 1'b1
    } path_src_e;
endpackage

// File: rtl/level_to_strobe.sv
module level_to_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic strobe
);
    typedef struct packed {
        logic seen;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = level;
        strobe    = level & ~st_q.seen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: one strobe per rising edge of the level
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    assert_pulse_needs_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> level);
endmodule

// File: rtl/sync_fifo.sv
module sync_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic wr_ok, rd_ok;

    always_comb begin
        full  = (st_q.cnt == CW'(DEPTH));
        empty = (st_q.cnt == '0);
        wr_ok = wr_en && !full;
        rd_ok = rd_en && !empty;
        st_d  = st_q;
        if (wr_ok) st_d.wptr = (st_q.wptr == LAST) ? '0 : st_q.wptr + 1'b1;
        if (rd_ok) begin
            st_d.rptr  = (st_q.rptr == LAST) ? '0 : st_q.rptr + 1'b1;
            st_d.rdata = mem[st_q.rptr];
        end
        st_d.cnt = st_q.cnt + CW'(wr_ok) - CW'(rd_ok);
        rd_data  = st_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[st_q.wptr] <= wr_data;
    end

    // R9: refused write leaves the store untouched
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && $stable(st_q.wptr)));
    // R10: refused read keeps data and emptiness
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data)));
    // R8: flags never both set, occupancy bounded
    assert_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full, empty}) && (st_q.cnt <= CW'(DEPTH)));
endmodule

// File: rtl/dbg_fifo_frontend.sv
module dbg_fifo_frontend #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin_wr_en,
    input  logic [DATA_W-1:0]   pin_wr_data,
    input  logic                pin_rd_en,
    input  logic [DATA_W+1:0]   dbg_wr_word,
    input  logic [1:0]          dbg_rd_word,
    output logic [DATA_W-1:0]   fifo_rd_data,
    output logic                fifo_full,
    output logic                fifo_empty,
    output logic                probe_wr_word,
    output logic [DATA_W:0]     probe_rd_word
);
    import dbg_fifo_pkg::*;

    localparam int WR_REQ_BIT = DATA_W;
    localparam int WR_SEL_BIT = DATA_W + 1;

    path_src_e wr_src, rd_src;
    logic dbg_wr_strobe, dbg_rd_strobe;
    logic fifo_wr, fifo_rd;
    logic [DATA_W-1:0] fifo_wdata;

    level_to_strobe u_wr_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (dbg_wr_word[WR_REQ_BIT]),
        .strobe (dbg_wr_strobe)
    );

    level_to_strobe u_rd_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (dbg_rd_word[RD_REQ_BIT]),
        .strobe (dbg_rd_strobe)
    );

    always_comb begin
        wr_src     = path_src_e'(dbg_wr_word[WR_SEL_BIT]);
        rd_src     = path_src_e'(dbg_rd_word[RD_SEL_BIT]);
        fifo_wr    = (wr_src == SRC_DEBUG) ? dbg_wr_strobe : pin_wr_en;
        fifo_wdata = (wr_src == SRC_DEBUG) ? dbg_wr_word[DATA_W-1:0] : pin_wr_data;
        fifo_rd    = (rd_src == SRC_DEBUG) ? dbg_rd_strobe : pin_rd_en;
    end

    sync_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fifo_wr),
        .wr_data (fifo_wdata),
        .rd_en   (fifo_rd),
        .rd_data (fifo_rd_data),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    always_comb begin
        probe_wr_word = fifo_full;
        probe_rd_word = {fifo_empty, fifo_rd_data};
    end
endmodule

// File: tb/dbg_fifo_frontend_test.sv
module dbg_fifo_frontend_test;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_wr_en = 1'b0;
    logic [DATA_W-1:0] pin_wr_data = '0;
    logic pin_rd_en = 1'b0;
    logic [DATA_W+1:0] dbg_wr_word = '0;
    logic [1:0] dbg_rd_word = '0;
    logic [DATA_W-1:0] fifo_rd_data;
    logic fifo_full, fifo_empty, probe_wr_word;
    logic [DATA_W:0] probe_rd_word;

    int n_chk = 0;
    int n_fail = 0;
    int model[$];
    int last_rd = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_fifo_frontend #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .pin_wr_en(pin_wr_en), .pin_wr_data(pin_wr_data), .pin_rd_en(pin_rd_en),
        .dbg_wr_word(dbg_wr_word), .dbg_rd_word(dbg_rd_word),
        .fifo_rd_data(fifo_rd_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .probe_wr_word(probe_wr_word), .probe_rd_word(probe_rd_word)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag);
        chk(probe_wr_word == (model.size() == DEPTH), {tag, " R8 full probe"},
            int'(probe_wr_word), int'(model.size() == DEPTH));
        chk(probe_rd_word[DATA_W] == (model.size() == 0), {tag, " R7 empty bit"},
            int'(probe_rd_word[DATA_W]), int'(model.size() == 0));
    endtask

    task automatic dbg_write(input int v, input int hold);
        dbg_wr_word = {2'b10, DATA_W'(v)};
        tick();
        dbg_wr_word = {2'b11, DATA_W'(v)};
        for (int h = 0; h < hold; h++) tick();
        dbg_wr_word = '0;
        tick();
        if (model.size() < DEPTH) model.push_back(v & 8'hFF);
    endtask

    task automatic dbg_read(input int hold);
        dbg_rd_word = 2'b01;
        tick();
        dbg_rd_word = 2'b11;
        for (int h = 0; h < hold; h++) tick();
        dbg_rd_word = 2'b00;
        tick();
        if (model.size() > 0) last_rd = model.pop_front();
    endtask

    task automatic pin_write(input int v);
        pin_wr_data = DATA_W'(v);
        pin_wr_en = 1'b1;
        tick();
        pin_wr_en = 1'b0;
        tick();
        if (model.size() < DEPTH) model.push_back(v & 8'hFF);
    endtask

    task automatic pin_read();
        pin_rd_en = 1'b1;
        tick();
        pin_rd_en = 1'b0;
        tick();
        if (model.size() > 0) last_rd = model.pop_front();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(fifo_empty == 1'b1, "R1 empty", int'(fifo_empty), 1);
        chk(fifo_full == 1'b0, "R1 full", int'(fifo_full), 0);
        chk(fifo_rd_data == '0, "R1 data", int'(fifo_rd_data), 0);

        // R10 read while empty through debug path
        dbg_read(3);
        chk(probe_rd_word == {1'b1, 8'h00}, "R10 empty read ignored", int'(probe_rd_word), 9'h100);

        // R3 debug word ignored when select is 0
        dbg_wr_word = {2'b01, 8'hAA};
        tick(); tick();
        dbg_wr_word = {2'b00, 8'h55};
        tick();
        dbg_wr_word = {2'b01, 8'h55};
        tick();
        dbg_wr_word = '0;
        tick();
        chk(fifo_empty == 1'b1, "R3 debug write ignored", int'(fifo_empty), 1);

        // R2 R4 R5 single write with long hold, then read it back
        dbg_write(8'h3C, 7);
        chk(model.size() == 1, "R4 model", model.size(), 1);
        chk_flags("R4");
        dbg_read(5);
        chk(fifo_rd_data == DATA_W'(last_rd), "R2 R4 data", int'(fifo_rd_data), last_rd);
        chk(fifo_empty == 1'b1, "R5 one write only", int'(fifo_empty), 1);

        // R8 R11 fill to full with computed values, mixed hold lengths
        for (int i = 0; i < DEPTH; i++) begin
            dbg_write((i * 37 + 5) & 8'hFF, (i % 4) + 1);
            chk_flags("R8 fill");
        end
        chk(probe_wr_word == 1'b1, "R8 full at DEPTH", int'(probe_wr_word), 1);

        // R9 write while full ignored (both paths)
        dbg_write(8'hEE, 2);
        pin_write(8'hDD);
        chk(fifo_full == 1'b1, "R9 still full", int'(fifo_full), 1);

        // R6 R7 R11 drain in order
        for (int i = 0; i < DEPTH; i++) begin
            dbg_read((i % 3) + 1);
            chk(probe_rd_word[DATA_W-1:0] == DATA_W'(last_rd), "R11 order",
                int'(probe_rd_word[DATA_W-1:0]), last_rd);
            chk_flags("R6 drain");
        end

        // R10 read while empty keeps data
        begin
            int keep;
            keep = last_rd;
            pin_read();
            dbg_read(2);
            chk(fifo_rd_data == DATA_W'(keep), "R10 data kept", int'(fifo_rd_data), keep);
            chk(fifo_empty == 1'b1, "R10 still empty", int'(fifo_empty), 1);
        end

        // R3 pin write path, R11 registered read timing
        pin_write(8'h81);
        pin_write(8'h42);
        chk_flags("R3 pin writes");

        // R12 debug read request ignored when select is 0
        dbg_rd_word = 2'b10;
        tick(); tick();
        dbg_rd_word = 2'b00;
        tick();
        chk(fifo_rd_data == DATA_W'(last_rd), "R12 debug read ignored", int'(fifo_rd_data), last_rd);
        chk(model.size() == 2 && fifo_empty == 1'b0, "R12 not empty", int'(fifo_empty), 0);

        // R11 read data valid the cycle after the pin read strobe
        pin_rd_en = 1'b1;
        tick();
        pin_rd_en = 1'b0;
        chk(fifo_rd_data == 8'h81, "R11 next-cycle data", int'(fifo_rd_data), 8'h81);
        last_rd = model.pop_front();
        tick();
        pin_read();
        chk(fifo_rd_data == 8'h42, "R12 pin read", int'(fifo_rd_data), 8'h42);
        chk_flags("R12 end");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule